// File: doc/BRIEF.md
# Host-to-SPI Byte Port

This block sits on a host's I/O bus and gives firmware a byte-wide path to an SD card that runs in SPI mode. A data write queues the byte and clocks it out on MOSI, most significant bit first, while the card's reply is captured from MISO. A data read clocks out 0xFF, which is the idle pattern the card expects while it is sending, and returns the byte that came back. A separate write-only port drives the card's chip select. Card commands and the initialisation sequence are left to firmware.

The two data addresses are aliases of the same register. A 16-bit word access, which the bus splits into two byte cycles, therefore runs two back-to-back exchanges. While an exchange runs, `io_busy` is high. The host bus holds the processor in wait until it falls, and the captured byte is then ready on `io_rdata`.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 1, io_busy is 0 and io_rdata is 0x00.
- R2: A write strobe to BASE or BASE+1 sends the written byte in SPI mode 0, MSB first, using exactly 8 rising edges of spi_sclk. MOSI changes only while spi_sclk is low.
- R3: A read strobe to BASE or BASE+1 sends 0xFF. When io_busy falls, io_rdata holds the 8 MISO bits sampled on the rising edges, MSB first.
- R4: A write to BASE+2 sets spi_cs_n to bit 0 of the written byte. Bits 7..1 are ignored and no exchange starts.
- R5: spi_cs_n changes only on a chip-select write. Data exchanges leave it as it was.
- R6: io_busy rises on the clock edge that accepts a data strobe and stays high for exactly 16*HALF_DIV clock cycles. Each spi_sclk phase lasts HALF_DIV cycles.
- R7: Any strobe presented while io_busy is high is ignored. It changes neither the byte being sent nor spi_cs_n.
- R8: The address is compared on bits 11..0 only. Data accesses match BASE with bit 0 masked, and the chip-select port matches BASE+2 exactly. A read of BASE+2, a write to BASE+3 and any access outside these matches have no effect.
- R9: Whenever io_busy is low, spi_sclk is 0 and spi_mosi is 1.
- R10: A data write also captures MISO, and the captured byte is returned on io_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Last byte received from the card |
| io_busy | output | 1 | Exchange in progress; host must wait |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data to card, idles high |
| spi_miso | input | 1 | SPI data from card |
| spi_cs_n | output | 1 | Card select, active low |

## Verification
The assertions assume that io_rd and io_wr are single-cycle strobes. They also assume that spi_miso is settled before each rising SCLK edge, since the block samples it on the same clock edge that raises SCLK. The stimulus drives every strobe for exactly one cycle on the falling clock edge. Its card model changes MISO only on falling SCLK edges, so MISO is always settled at least one SCLK phase before it is sampled. The assertions make no assumption about strobes that arrive while io_busy is high, and the stimulus issues such strobes on purpose.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;
    localparam int DEC_W  = 12;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  xfer_go;
        byte_t xfer_byte;
        logic  sel_we;
        logic  sel_val;
    } host_req_t;

endpackage

// File: rtl/spi_port_decode.sv
module spi_port_decode
    import spi_port_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0280
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  byte_t             io_wdata,
    input  logic              busy,
    output host_req_t         req
);

    localparam logic [ADDR_W-1:0] DATA_MASK = ADDR_W'((1 << DEC_W) - 2);
    localparam logic [ADDR_W-1:0] SEL_MASK  = ADDR_W'((1 << DEC_W) - 1);
    localparam logic [ADDR_W-1:0] DATA_KEY  = BASE_ADDR & DATA_MASK;
    localparam logic [ADDR_W-1:0] SEL_KEY   = (BASE_ADDR + ADDR_W'(2)) & SEL_MASK;

    generate
        if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
            $error("BASE_ADDR must be even");
        end
    endgenerate

    logic data_hit;
    logic sel_hit;

    always_comb begin
        data_hit = (io_addr & DATA_MASK) == DATA_KEY;
        sel_hit  = (io_addr & SEL_MASK) == SEL_KEY;

        req           = '0;
        req.xfer_byte = '1;
        if (!busy) begin
            if (io_wr && data_hit) begin
                req.xfer_go   = 1'b1;
                req.xfer_byte = io_wdata;
            end else if (io_wr && sel_hit) begin
                req.sel_we  = 1'b1;
                req.sel_val = io_wdata[0];
            end else if (io_rd && data_hit) begin
                req.xfer_go   = 1'b1;
                req.xfer_byte = '1;
            end
        end
    end

endmodule

// File: rtl/spi_port_select.sv
module spi_port_select (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_we,
    input  logic sel_val,
    output logic cs_n
);

    typedef struct packed {
        logic cs_n;
    } sel_state_t;

    sel_state_t sel_d;
    sel_state_t sel_q;

    always_comb begin
        sel_d = sel_q;
        if (sel_we) begin
            sel_d.cs_n = sel_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q.cs_n <= 1'b1;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign cs_n = sel_q.cs_n;

    // R5: chip select moves only on its own write
    p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(cs_n));

    // R4: a select write lands in one cycle
    p_cs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (cs_n == $past(sel_val)));

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter
    import spi_port_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go,
    input  byte_t tx_byte,
    input  logic  miso,
    output logic  sclk,
    output logic  mosi,
    output logic  busy,
    output byte_t rx_byte
);

    localparam int CNT_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_END = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        byte_t            tx;
        byte_t            rx;
    } shf_state_t;

    shf_state_t shf_d;
    shf_state_t shf_q;

    always_comb begin
        shf_d = shf_q;
        if (!shf_q.busy) begin
            if (go) begin
                shf_d.busy = 1'b1;
                shf_d.sclk = 1'b0;
                shf_d.cnt  = '0;
                shf_d.bits = '0;
                shf_d.tx   = tx_byte;
            end
        end else if (shf_q.cnt == CNT_END) begin
            shf_d.cnt = '0;
            if (!shf_q.sclk) begin
                shf_d.sclk = 1'b1;
                shf_d.rx   = {shf_q.rx[BYTE_W-2:0], miso};
            end else begin
                shf_d.sclk = 1'b0;
                shf_d.tx   = {shf_q.tx[BYTE_W-2:0], 1'b1};
                if (shf_q.bits == BIT_END) begin
                    shf_d.busy = 1'b0;
                end else begin
                    shf_d.bits = shf_q.bits + BIT_W'(1);
                end
            end
        end else begin
            shf_d.cnt = shf_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q.busy <= 1'b0;
            shf_q.sclk <= 1'b0;
            shf_q.cnt  <= '0;
            shf_q.bits <= '0;
            shf_q.tx   <= '1;
            shf_q.rx   <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign sclk    = shf_q.sclk;
    assign mosi    = shf_q.busy ? shf_q.tx[BYTE_W-1] : 1'b1;
    assign busy    = shf_q.busy;
    assign rx_byte = shf_q.rx;

    // R6: an accepted start raises busy on the next edge
    p_go_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R2: mosi never moves while sclk is high
    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R3: captured byte stays put between exchanges
    p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(rx_byte));

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0280,
    parameter int                HALF_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_busy,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);

    host_req_t req;
    logic      busy;

    spi_port_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .busy     (busy),
        .req      (req)
    );

    spi_port_shifter #(
        .HALF_DIV (HALF_DIV)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (req.xfer_go),
        .tx_byte (req.xfer_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (busy),
        .rx_byte (io_rdata)
    );

    spi_port_select u_select (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_we (req.sel_we),
        .sel_val(req.sel_val),
        .cs_n   (spi_cs_n)
    );

    assign io_busy = busy;

    // R9: idle bus lines
    p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_busy |-> (!spi_sclk && spi_mosi));

    // R7: no new start and no select change while busy
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_busy |-> (!req.xfer_go && !req.sel_we));

    // R5: an exchange never moves chip select
    p_cs_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_busy && $past(io_busy)) |-> $stable(spi_cs_n));

endmodule

// File: tb/tb_spi_byte_port.sv
module tb_spi_byte_port;

    localparam int HALF_DIV = 2;
    localparam int BUSY_LEN = 16 * HALF_DIV;
    localparam logic [15:0] BASE = 16'h0280;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_busy;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;
    logic        spi_cs_n;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    spi_byte_port #(
        .ADDR_W    (16),
        .BASE_ADDR (BASE),
        .HALF_DIV  (HALF_DIV)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .io_busy  (io_busy),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .spi_cs_n (spi_cs_n)
    );

    // card model: MISO moves on falling SCLK, MOSI captured on rising SCLK
    logic [7:0] card_tx = 8'h00;
    logic [7:0] card_rx = 8'h00;
    int rises = 0;
    int falls = 0;
    int base_falls = 0;
    int base_rises = 0;
    int rel;
    logic mosi_moved_high = 1'b0;

    always @(posedge spi_sclk) begin
        card_rx <= {card_rx[6:0], spi_mosi};
        rises <= rises + 1;
    end
    always @(negedge spi_sclk) falls <= falls + 1;
    always @(spi_mosi) if (spi_sclk) mosi_moved_high <= 1'b1;

    assign rel = falls - base_falls;
    assign spi_miso = (rel >= 0 && rel < 8) ? card_tx[7 - rel] : 1'b1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prep_card(input logic [7:0] reply);
        card_tx = reply;
        base_falls = falls;
        base_rises = rises;
    endtask

    // strobe one access, return cycles busy was seen high
    task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d,
                          output int busy_cycles);
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = !w; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        busy_cycles = 0;
        while (io_busy && busy_cycles < 1000) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 cs_n", spi_cs_n, 1);
        check("R1 sclk", spi_sclk, 0);
        check("R1 mosi", spi_mosi, 1);
        check("R1 busy", io_busy, 0);
        check("R1 rdata", io_rdata, 0);
    endtask

    task automatic t_write_data();
        int bc;
        prep_card(8'h3C);
        access(BASE, 1'b1, 8'hA5, bc);
        check("R2 mosi byte", card_rx, 8'hA5);
        check("R2 edge count", rises - base_rises, 8);
        check("R2 mosi steady", mosi_moved_high, 0);
        check("R6 busy length", bc, BUSY_LEN);
        check("R10 rdata on write", io_rdata, 8'h3C);
        check("R5 cs after write", spi_cs_n, 1);
        check("R9 idle sclk", spi_sclk, 0);
        check("R9 idle mosi", spi_mosi, 1);
    endtask

    task automatic t_write_alias();
        int bc;
        prep_card(8'hC3);
        access(BASE + 16'd1, 1'b1, 8'h5A, bc);
        check("R2 alias mosi byte", card_rx, 8'h5A);
        check("R10 alias rdata", io_rdata, 8'hC3);
    endtask

    task automatic t_read();
        int bc;
        prep_card(8'h96);
        access(BASE, 1'b0, 8'h00, bc);
        check("R3 read rdata", io_rdata, 8'h96);
        check("R3 read sends FF", card_rx, 8'hFF);
        check("R6 read busy length", bc, BUSY_LEN);
        prep_card(8'h01);
        access(BASE + 16'd1, 1'b0, 8'h00, bc);
        check("R3 alias read rdata", io_rdata, 8'h01);
    endtask

    task automatic t_select();
        int bc;
        access(BASE + 16'd2, 1'b1, 8'hFE, bc);
        check("R4 cs low", spi_cs_n, 0);
        check("R4 no exchange", bc, 0);
        prep_card(8'h77);
        access(BASE, 1'b1, 8'h11, bc);
        check("R5 cs held low", spi_cs_n, 0);
        access(BASE + 16'd2, 1'b1, 8'h01, bc);
        check("R4 cs high", spi_cs_n, 1);
    endtask

    task automatic t_busy_ignore();
        int bc;
        prep_card(8'h42);
        @(negedge clk);
        io_addr = BASE; io_wr = 1'b1; io_wdata = 8'hC6;
        @(negedge clk);
        io_addr = BASE + 16'd2; io_wdata = 8'h00;
        @(negedge clk);
        io_addr = BASE; io_wdata = 8'h0F;
        @(negedge clk);
        io_wr = 1'b0;
        bc = 0;
        while (io_busy && bc < 1000) begin
            bc++;
            @(negedge clk);
        end
        check("R7 byte unchanged", card_rx, 8'hC6);
        check("R7 edge count", rises - base_rises, 8);
        check("R7 cs unchanged", spi_cs_n, 1);
        @(negedge clk);
        check("R7 no queued start", io_busy, 0);
    endtask

    task automatic t_decode();
        int bc;
        int r0;
        prep_card(8'hE7);
        access(BASE | 16'hF000, 1'b1, 8'h81, bc);
        check("R8 upper bits ignored", card_rx, 8'h81);
        r0 = rises;
        access(BASE + 16'd2, 1'b0, 8'h00, bc);
        check("R8 read of select port", bc, 0);
        check("R8 read no edges", rises - r0, 0);
        check("R8 rdata kept", io_rdata, 8'hE7);
        access(BASE + 16'd3, 1'b1, 8'h00, bc);
        check("R8 write base+3 cs", spi_cs_n, 1);
        check("R8 write base+3 idle", bc, 0);
        access(BASE + 16'd4, 1'b1, 8'h00, bc);
        check("R8 outside window", bc + (rises - r0), 0);
        access(BASE - 16'd2, 1'b0, 8'h00, bc);
        check("R8 below window", bc, 0);
        check("R8 cs final", spi_cs_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_data();
        t_write_alias();
        t_read();
        t_select();
        t_busy_ignore();
        t_decode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule